// File: doc/BRIEF.md
# Bus-Stall Timeout Timer

This block guards a serial-bus master against a clock line that a target holds low for too long. The bus engine raises `stall_i` while the master waits on a stretched clock. While the timer is enabled and the stall holds, the block counts prescaled ticks. When the count reaches a programmed limit, it sets a sticky timeout status bit. The prescaler divides the system clock by a power of two, chosen by a log2 field. The limit is a 15-bit value. Software picks the smallest shift that makes its wanted wait fit in 15 bits.

Software sees four small registers. The control word holds the enable at bit 15 and the limit in bits 14:0. Writing it with the enable cleared parks the timer and keeps the limit, so software can drop the enable around a command and raise it again. The other registers are the prescale shift, the sticky status word and the interrupt mask. Besides the timeout, the status word collects other event pulses from the bus engine. Each source can be masked on its own, so the timeout can stay armed across a sequence of messages while the other sources come and go.

Top module: `stall_tmo_timer`

## Requirements
- R1: After reset, every register reads 0, and `timeout_o` and `irq_o` are 0.
- R2: Register address 0 (control) holds the limit in bits 14:0 and the enable in bit 15. It reads back exactly as written. Read data appears on `rd_data_o` one clock after `rd_addr_i` is presented.
- R3: Register address 1 holds the prescale shift N in bits 3:0. A written value above 14 is stored as 14.
- R4: Take enable set, limit L and shift N, with `stall_i` held high from a point where the count is idle. Status bit 7 at address 2 becomes 1 after exactly (L << N) + 1 rising clock edges with the stall high. It is still 0 after (L << N) edges. L = 0 fires on the first edge.
- R5: A single cycle with `stall_i` low restarts the count from zero.
- R6: While the enable is 0, no timeout is raised however long the stall lasts, and the limit field keeps its value. Raising the enable again restarts the count from zero.
- R7: Status bits are sticky. Writing 1 to a bit at address 2 clears it, and writing 0 leaves it. A set in the same cycle as a clear wins, so a timeout cannot be cleared while the stall condition that raised it persists.
- R8: A pulse on bit i of `evt_i` sets status bit i, which stays sticky. Bit 7 of `evt_i` is ignored, because that position belongs to the timeout.
- R9: `irq_o` is 1 exactly one clock after any status bit is 1 whose mask bit at address 3 is 1. It is 0 one clock after no such bit remains.
- R10: `timeout_o` equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Bus clock held stalled by a target while the master waits |
| evt_i | input | 16 | One-cycle event pulses from the bus engine; bit 7 unused |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Registered read data |
| timeout_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims at the exact edge of expiry: a limit of zero, the largest limit with no prescale, the largest shift, and random limit and shift pairs. An off-by-one in the prescaler or the compare would raise the flag one tick early or late. It breaks a stall one cycle short of expiry and then counts a full window again; a counter that failed to restart would fire early. It drops and raises the enable in the middle of a stall, and checks that the limit survives and that the count starts afresh. It also tries to clear the flag while the stall persists, and checks that the flag stays set. A design that gave the clear priority would lose a live timeout.

// File: rtl/stall_tmo_pkg.sv
package stall_tmo_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DIV  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_MASK = 2'd3
  } reg_addr_e;

  localparam int unsigned TMO_BIT = 7;
endpackage

// File: rtl/stall_tmo_prescaler.sv
module stall_tmo_prescaler #(
  parameter int unsigned PRE_W = 14,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] shift,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   full;
  logic [PRE_W:0]   span;

  // Terminal value of the divider: 2^shift - 1
  always_comb begin
    full = (PRE_W+1)'(1) << shift;
    span = full - (PRE_W+1)'(1);
    tick = run && (cnt_q == span[PRE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/stall_tmo_counter.sv
module stall_tmo_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == limit);

  // Holds at the limit once reached, so the flag keeps being set while stalled
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick && !expire) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stall_tmo_regs.sv
module stall_tmo_regs
  import stall_tmo_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DATA_W  = CNT_W + 1,
  parameter int unsigned PRE_MAX = CNT_W - 1,
  parameter int unsigned DIV_W   = $clog2(PRE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [DATA_W-1:0] evt,
  input  logic              expire,
  output logic [DATA_W-1:0] rd_data,
  output logic              en,
  output logic [CNT_W-1:0]  limit,
  output logic [DIV_W-1:0]  shift,
  output logic [DATA_W-1:0] mask,
  output logic              timeout,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TMO_ONEHOT = DATA_W'(1) << TMO_BIT;

  logic [DATA_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] mask_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_q;

  logic              wr_ctrl, wr_div, wr_stat, wr_mask;
  logic [DIV_W-1:0]  div_in;
  logic [DATA_W-1:0] stat_set, stat_clr, stat_d;

  always_comb begin
    wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
    wr_div  = wr_en && (reg_addr_e'(wr_addr) == ADDR_DIV);
    wr_stat = wr_en && (reg_addr_e'(wr_addr) == ADDR_STAT);
    wr_mask = wr_en && (reg_addr_e'(wr_addr) == ADDR_MASK);
    div_in  = (32'(wr_data[DIV_W-1:0]) > PRE_MAX) ? DIV_W'(PRE_MAX)
                                                  : wr_data[DIV_W-1:0];
    stat_set = (evt & ~TMO_ONEHOT) | (expire ? TMO_ONEHOT : '0);
    stat_clr = wr_stat ? wr_data : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_div)  div_q  <= div_in;
      if (wr_mask) mask_q <= wr_data;
      stat_q <= stat_d;
      irq_q  <= |(stat_q & mask_q);
      case (reg_addr_e'(rd_addr))
        ADDR_CTRL: rd_q <= ctrl_q;
        ADDR_DIV:  rd_q <= DATA_W'(div_q);
        ADDR_STAT: rd_q <= stat_q;
        default:   rd_q <= mask_q;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign en      = ctrl_q[DATA_W-1];
  assign limit   = ctrl_q[CNT_W-1:0];
  assign shift   = div_q;
  assign mask    = mask_q;
  assign timeout = stat_q[TMO_BIT];
  assign irq     = irq_q;
endmodule

// File: rtl/stall_tmo_timer.sv
module stall_tmo_timer
  import stall_tmo_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DATA_W  = CNT_W + 1,
  parameter int unsigned PRE_MAX = CNT_W - 1,
  parameter int unsigned DIV_W   = $clog2(PRE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              timeout_o,
  output logic              irq_o
);
  logic              ctrl_en;
  logic [CNT_W-1:0]  ctrl_limit;
  logic [DIV_W-1:0]  div_val;
  logic [DATA_W-1:0] irq_mask;
  logic              run, tick, expire;

  assign run = stall_i && ctrl_en;

  stall_tmo_prescaler #(.PRE_W(PRE_MAX), .DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .shift(div_val), .tick(tick)
  );

  stall_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .limit(ctrl_limit), .expire(expire)
  );

  stall_tmo_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .PRE_MAX(PRE_MAX), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .evt(evt_i), .expire(expire),
    .rd_data(rd_data_o), .en(ctrl_en), .limit(ctrl_limit),
    .shift(div_val), .mask(irq_mask), .timeout(timeout_o), .irq(irq_o)
  );
endmodule

// File: rtl/stall_tmo_chk.sv
module stall_tmo_chk #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_MAX = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              stat_clr,
  input logic              en,
  input logic [DIV_W-1:0]  div,
  input logic [DATA_W-1:0] mask,
  input logic              timeout_o,
  input logic              irq_o
);
  // R4: no expiry in a cycle without stall
  a_r4_needs_stall: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !timeout_o) |=> !timeout_o);

  // R6: no expiry while disabled
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (!en && !timeout_o) |=> !timeout_o);

  // R7: flag is sticky unless cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !stat_clr) |=> timeout_o);

  // R9: an all-zero mask keeps the request low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq_o);

  // R3: stored shift never exceeds the largest setting
  a_r3_div_range: assert property (@(posedge clk) disable iff (rst)
    (32'(div) <= PRE_MAX));
endmodule

bind stall_tmo_timer stall_tmo_chk #(
  .DIV_W(DIV_W), .DATA_W(DATA_W), .PRE_MAX(PRE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .stall_i(stall_i),
  .stat_clr(wr_en_i && (wr_addr_i == 2'd2) && wr_data_i[7]),
  .en(ctrl_en), .div(div_val), .mask(irq_mask),
  .timeout_o(timeout_o), .irq_o(irq_o)
);

// File: tb/stall_tmo_timer_tb.sv
module stall_tmo_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic [15:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        timeout_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;  // 250 MHz

  stall_tmo_timer u_dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .timeout_o(timeout_o), .irq_o(irq_o)
  );

  function automatic int exp_edges(int lim, int sh);
    return lim << sh;
  endfunction

  function automatic int exp_div(int v);
    return (v > 14) ? 14 : v;
  endfunction

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cycles);
      report();
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    rd_addr_i = a;
    @(posedge clk); @(negedge clk);
    d = int'(rd_data_o);
  endtask

  task automatic expire_test(string req, int lim, int sh);
    int e, d;
    e = exp_edges(lim, sh);
    stall_i = 1'b0;
    wr(2'd1, 16'(sh));
    wr(2'd0, 16'h8000 | 16'(lim));
    wr(2'd2, 16'h0080);
    stall_i = 1'b1;
    if (e > 0) begin
      step(e);
      check({req, " early"}, int'(timeout_o), 0);
    end
    step(1);
    check({req, " on time"}, int'(timeout_o), 1);
    rd(2'd2, d);
    check("R10 status bit matches timeout_o", (d >> 7) & 1, int'(timeout_o));
    stall_i = 1'b0;
    wr(2'd2, 16'h0080);
    check("R7 cleared", int'(timeout_o), 0);
  endtask

  initial begin
    int d, lim, sh, e;
    void'($urandom(32'd20240611));
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset register", d, 0);
    end
    check("R1 timeout_o", int'(timeout_o), 0);
    check("R1 irq_o", int'(irq_o), 0);

    // R2 control readback
    wr(2'd0, 16'h5A3C); rd(2'd0, d); check("R2 readback", d, 16'h5A3C);
    wr(2'd0, 16'h8123); rd(2'd0, d); check("R2 readback en", d, 16'h8123);

    // R3 prescale clamp
    wr(2'd1, 16'd15); rd(2'd1, d); check("R3 clamp 15", d, exp_div(15));
    wr(2'd1, 16'd9);  rd(2'd1, d); check("R3 keep 9", d, exp_div(9));
    wr(2'd0, 16'h0000);

    // R4 directed corners
    expire_test("R4 L0", 0, 0);
    expire_test("R4 L1", 1, 0);
    expire_test("R4 L3N2", 3, 2);
    expire_test("R4 maxshift", 1, 14);
    expire_test("R4 maxlimit", 16'h7FFF, 0);

    // R4 random
    for (int i = 0; i < 10; i++) begin
      lim = 1 + int'($urandom_range(39));
      sh  = int'($urandom_range(5));
      expire_test("R4 random", lim, sh);
    end

    // R5 stall break restarts count
    wr(2'd1, 16'd1); wr(2'd0, 16'h8005); e = exp_edges(5, 1);
    stall_i = 1'b1; step(e - 1);
    stall_i = 1'b0; step(1);
    stall_i = 1'b1; step(e);
    check("R5 restart no early fire", int'(timeout_o), 0);
    step(1);
    check("R5 fires after full window", int'(timeout_o), 1);
    stall_i = 1'b0; wr(2'd2, 16'h0080);

    // R6 enable drop keeps value, re-enable restarts
    wr(2'd1, 16'd1); wr(2'd0, 16'h8004); e = exp_edges(4, 1);
    stall_i = 1'b1; step(e - 2);
    wr(2'd0, 16'h0004);
    step(50);
    check("R6 disabled no timeout", int'(timeout_o), 0);
    rd(2'd0, d);
    check("R6 value kept", d, 16'h0004);
    wr(2'd0, 16'h8004);
    step(e);
    check("R6 restart no early fire", int'(timeout_o), 0);
    step(1);
    check("R6 fires after re-enable", int'(timeout_o), 1);

    // R7 set wins over clear while still stalled; write 0 no effect
    wr(2'd2, 16'h0080);
    check("R7 set beats clear", int'(timeout_o), 1);
    stall_i = 1'b0;
    wr(2'd2, 16'h0000);
    check("R7 write 0 ignored", int'(timeout_o), 1);
    wr(2'd2, 16'h0080);
    check("R7 w1c", int'(timeout_o), 0);

    // R9 interrupt latency
    wr(2'd3, 16'h0080);
    wr(2'd1, 16'd0); wr(2'd0, 16'h8002); e = exp_edges(2, 0);
    stall_i = 1'b1; step(e + 1);
    check("R9 status set", int'(timeout_o), 1);
    check("R9 irq one cycle later (not yet)", int'(irq_o), 0);
    step(1);
    check("R9 irq raised", int'(irq_o), 1);
    stall_i = 1'b0;
    wr(2'd2, 16'h0080);
    check("R9 irq lags clear", int'(irq_o), 1);
    step(1);
    check("R9 irq dropped", int'(irq_o), 0);
    wr(2'd3, 16'h0000);

    // R8 other event sources
    evt_i = 16'h0008; step(1); evt_i = '0;
    rd(2'd2, d); check("R8 event sticky", d, 16'h0008);
    wr(2'd3, 16'h0008); step(1);
    check("R8 masked event irq", int'(irq_o), 1);
    evt_i = 16'h0080; step(1); evt_i = '0;
    rd(2'd2, d); check("R8 bit7 event ignored", d, 16'h0008);
    check("R8 no timeout from evt", int'(timeout_o), 0);
    wr(2'd2, 16'h0008);
    rd(2'd2, d); check("R8 event cleared", d, 0);

    report();
  end
endmodule